// File: doc/BRIEF.md
# Bit-Stacking Population Counter (6:3 / 7:3)

This block counts how many of its six or seven equally weighted input bits are one and presents the total as a 3-bit binary number. It is intended as the column-reduction cell of a multiplier partial-product tree, where it takes the place of a cascade of full adders.

The count is not formed by adders. Each group of three inputs is first sorted into a thermometer-style stack, with the ones packed toward the low end. The two stacks are then merged symmetrically with OR and AND gates. The output bits are read from the stack bits. The single XOR used for the low bit combines two parity flags that are ready early, so it does not lengthen the longest path.

In the seven-input variant, both the six-input count and the same count plus one are built in parallel. The seventh input then selects between them through a 2:1 multiplexer. The block has no storage: its output follows its inputs in the same cycle.

Top module: `bitstack_counter`

## Requirements
- R1: With NUM_IN = 6, `count_out` equals the number of ones in `bits_in`, for all 64 input patterns.
- R2: `count_out[0]` is 1 exactly when an odd number of inputs are one.
- R3: `count_out[2]` is 1 exactly when four or more inputs are one.
- R4: `count_out[1]` is 1 exactly when the number of ones is 2, 3, 6 or 7.
- R5: With NUM_IN = 7, `count_out` equals the number of ones in `bits_in`, for all 128 input patterns.
- R6: With NUM_IN = 7, setting `bits_in[6]` raises `count_out` by exactly one over the value given by the same low six bits with `bits_in[6]` clear.
- R7: The result depends only on how many inputs are one, not on their positions. Rotating the input vector leaves `count_out` unchanged.
- R8: All inputs zero give `count_out` = 0. All inputs one give `count_out` = NUM_IN.
- R9: The block is purely combinational. `count_out` reflects a new `bits_in` value without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bits_in | input | NUM_IN | Equally weighted bits to be counted (NUM_IN is 6 or 7) |
| count_out | output | 3 | Binary number of ones in `bits_in` |

## Verification
The assertions assume that `bits_in` is fully driven with known 0/1 values. They are skipped while any input bit is unknown, because the stack logic has no defined result in that case. The stimulus meets this assumption by driving every input bit to a defined value from time zero. It does this through the exhaustive sweeps, the directed all-zero and all-one patterns, and the seeded random patterns. The seventh-input increment and the rotation checks compare two legal input values against each other, so they rely on the same rule.

// File: rtl/bitstack_pkg.sv
package bitstack_pkg;
  localparam int STACK_W = 3;
  localparam int CNT_W   = 3;

  // Thermometer stack: ones packed toward bit 0
  typedef logic [STACK_W-1:0] stack3_t;

  typedef struct packed {
    logic hi;   // weight 4
    logic mid;  // weight 2
    logic lo;   // weight 1
  } count3_t;
endpackage

// File: rtl/bitstack_sort3.sv
module bitstack_sort3
  import bitstack_pkg::*;
(
  input  logic [2:0] raw,
  output stack3_t    stk
);
  always_comb begin
    stk[0] = raw[0] | raw[1] | raw[2];
    stk[1] = (raw[0] & raw[1]) | (raw[0] & raw[2]) | (raw[1] & raw[2]);
    stk[2] = raw[0] & raw[1] & raw[2];
  end
endmodule

// File: rtl/bitstack_merge.sv
module bitstack_merge
  import bitstack_pkg::*;
(
  input  stack3_t lo_stk,
  input  stack3_t hi_stk,
  output count3_t base_cnt,
  output count3_t plus_cnt
);
  logic [2:0] fill_or;
  logic [2:0] fill_and;
  logic       fill_full;
  logic       any_over;
  logic       lo_even;
  logic       hi_even;
  logic       atleast_two;

  // Symmetric merge: low stack reversed against high stack
  always_comb begin
    fill_or[0]  = lo_stk[2] | hi_stk[0];
    fill_or[1]  = lo_stk[1] | hi_stk[1];
    fill_or[2]  = lo_stk[0] | hi_stk[2];
    fill_and[0] = lo_stk[2] & hi_stk[0];
    fill_and[1] = lo_stk[1] & hi_stk[1];
    fill_and[2] = lo_stk[0] & hi_stk[2];
    fill_full   = &fill_or;   // count >= 3
    any_over    = |fill_and;  // count >= 4
  end

  // Parity read directly from each stack
  always_comb begin
    lo_even     = ~lo_stk[0] | (lo_stk[1] & ~lo_stk[2]);
    hi_even     = ~hi_stk[0] | (hi_stk[1] & ~hi_stk[2]);
    atleast_two = lo_stk[1] | hi_stk[1] | (lo_stk[0] & hi_stk[0]);
  end

  always_comb begin
    base_cnt.lo  = lo_even ^ hi_even;
    base_cnt.hi  = any_over;
    base_cnt.mid = (atleast_two & ~any_over) | (lo_stk[2] & hi_stk[2]);

    plus_cnt.lo  = ~(lo_even ^ hi_even);
    plus_cnt.hi  = fill_full;
    plus_cnt.mid = ((lo_stk[0] | hi_stk[0]) & ~fill_full)
                 | (lo_stk[2] & hi_stk[1])
                 | (lo_stk[1] & hi_stk[2]);
  end
endmodule

// File: rtl/bitstack_counter.sv
module bitstack_counter
  import bitstack_pkg::*;
#(
  parameter int NUM_IN = 7
) (
  input  logic [NUM_IN-1:0] bits_in,
  output logic [2:0]        count_out
);
  localparam int GROUP_W = 3;

  stack3_t grp_stk [2];
  count3_t base_cnt;
  count3_t plus_cnt;
  logic    inc_sel;

  for (genvar g = 0; g < 2; g++) begin : g_sort
    bitstack_sort3 u_sort (
      .raw (bits_in[g*GROUP_W +: GROUP_W]),
      .stk (grp_stk[g])
    );
  end

  bitstack_merge u_merge (
    .lo_stk   (grp_stk[0]),
    .hi_stk   (grp_stk[1]),
    .base_cnt (base_cnt),
    .plus_cnt (plus_cnt)
  );

  if (NUM_IN == 7) begin : g_seven
    assign inc_sel = bits_in[NUM_IN-1];
  end else begin : g_six
    assign inc_sel = 1'b0;
  end

  assign count_out = inc_sel ? plus_cnt : base_cnt;
endmodule

// File: rtl/bitstack_counter_chk.sv
module bitstack_counter_chk #(
  parameter int NUM_IN = 7
) (
  input logic [NUM_IN-1:0] bits_in,
  input logic [2:0]        count_out
);
  always_comb begin
    if (!$isunknown(bits_in)) begin
      a_r1_total_matches: assert (int'(count_out) == $countones(bits_in))
        else $error("count mismatch");
      a_r2_low_is_parity: assert (count_out[0] == ($countones(bits_in) % 2 == 1))
        else $error("parity bit wrong");
      a_r3_top_from_four: assert (count_out[2] == ($countones(bits_in) >= 4))
        else $error("top bit wrong");
      a_r4_mid_pattern: assert (count_out[1] == ((($countones(bits_in) / 2) % 2) == 1))
        else $error("middle bit wrong");
      a_r8_within_range: assert (int'(count_out) <= NUM_IN)
        else $error("count above input width");
    end
  end
endmodule

bind bitstack_counter bitstack_counter_chk #(.NUM_IN(NUM_IN)) u_chk (
  .bits_in   (bits_in),
  .count_out (count_out)
);

// File: tb/bitstack_counter_test.sv
module bitstack_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] in7 = '0;
  logic [5:0] in6 = '0;
  logic [2:0] out7;
  logic [2:0] out6;
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  bitstack_counter #(.NUM_IN(7)) uut  (.bits_in(in7), .count_out(out7));
  bitstack_counter #(.NUM_IN(6)) uut6 (.bits_in(in6), .count_out(out6));

  function automatic int ones(input logic [6:0] v);
    int c = 0;
    for (int i = 0; i < 7; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    #2;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int base;
    logic [6:0] rot;
    int first;
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // R8: all-zero state and all-ones
    step();
    check("R8 zeros 7", int'(out7), 0);
    check("R8 zeros 6", int'(out6), 0);
    in7 = 7'h7f; in6 = 6'h3f; step();
    check("R8 ones 7", int'(out7), 7);
    check("R8 ones 6", int'(out6), 6);

    // R9: no clock needed, value visible 1 ns after a change
    in7 = 7'b0010110;
    #1;
    check("R9 combinational", int'(out7), 3);

    // R1-style exhaustive six-input sweep, with bit checks R2 R3 R4
    for (int p = 0; p < 64; p++) begin
      in6 = 6'(p); step();
      check("R1 count6", int'(out6), ones({1'b0, 6'(p)}));
      check("R2 parity6", int'(out6[0]), ones({1'b0, 6'(p)}) % 2);
      check("R3 top6", int'(out6[2]), int'(ones({1'b0, 6'(p)}) >= 4));
      check("R4 mid6", int'(out6[1]), (ones({1'b0, 6'(p)}) / 2) % 2);
    end

    // R5: exhaustive seven-input sweep
    for (int p = 0; p < 128; p++) begin
      in7 = 7'(p); step();
      check("R5 count7", int'(out7), ones(7'(p)));
    end

    // R6: seventh input adds exactly one
    for (int p = 0; p < 64; p++) begin
      in7 = {1'b0, 6'(p)}; step();
      base = int'(out7);
      in7 = {1'b1, 6'(p)}; step();
      check("R6 increment", int'(out7), base + 1);
    end

    // R7: random patterns, rotation invariance
    for (int k = 0; k < 200; k++) begin
      rot = 7'($urandom);
      in7 = rot; step();
      first = int'(out7);
      check("R5 random", first, ones(rot));
      rot = {rot[5:0], rot[6]};
      in7 = rot; step();
      check("R7 rotate", int'(out7), first);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule